// File: doc/BRIEF.md
# Multi-Purpose Register Mode Command Handler

This block sits on the device side of a double-data-rate DRAM command interface. It decodes mode-register writes that target mode register 3, keeps the state that says whether multi-purpose register (MPR) mode is on, and checks every incoming command against the rules for that mode. A violation produces a one-cycle error pulse. An illegal command never changes the mode.

While MPR mode is on, a read or read-with-auto-precharge does not go to the memory array. The block raises a same-cycle select so the array path stays idle. After a parameterised read latency it drives a fixed calibration burst of eight beats, with a data-valid strobe. The memory array, refresh and I/O timing belong to other blocks.

Top module: `mpr_cmd_unit`

## Requirements
- R1: While `rst_ni` is low, `mpr_en_o`, `mpr_valid_o` and `err_o` are 0 and `mpr_data_o` is all zeros.
- R2: A mode-register write is chip select, RAS, CAS and WE all low with `cke_i` high. When it carries bank address 3'b011, A15..A3 = 0 and every bit of `bank_idle_i` set, it loads A2 into `mpr_en_o` after the next clock edge. A1:A0 must be 00 when A2 = 1. When A2 = 0, A1:A0 may hold any value and are ignored.
- R3: In normal mode, a mode-register write with BA[1:0] other than 2'b11 leaves `mpr_en_o` unchanged and raises no error.
- R4: A mode-register write with BA[1:0] = 2'b11 and either BA2 = 1 or any of A15..A3 set pulses `err_o` for one cycle after the edge and leaves the mode unchanged.
- R5: A write that sets A2 = 1 with A1:A0 other than 00 pulses `err_o` and leaves MPR mode off.
- R6: A mode-register-3 write while any bit of `bank_idle_i` is 0 pulses `err_o` and leaves the mode unchanged.
- R7: The read command is chip select low, RAS high, CAS low, WE high; A10 = 1 makes it a read with auto-precharge. In MPR mode with `cke_i` high, `rd_src_mpr_o` is 1 in the same cycle as the read. In normal mode it stays 0 and no burst follows.
- R8: A redirected read sampled at edge k makes `mpr_valid_o` high after edges k+RD_LAT through k+RD_LAT+7, exactly 8 cycles. On beat n (0..7), every bit of `mpr_data_o` equals n mod 2. `mpr_data_o` is zero whenever `mpr_valid_o` is low.
- R9: In MPR mode, `err_o` pulses after the edge for any of the following, and the mode stays on:
  - `cke_i` low;
  - any command other than deselect, NOP (RAS, CAS, WE high), read, or a legal mode-register-3 write with A2 = 0;
  - this includes writes to mode registers 0..2 and a mode-register-3 write with A2 = 1.
- R10: An asynchronous reset during MPR mode clears `mpr_en_o` and cancels any burst in flight.
- R11: In normal mode, commands other than mode-register-3 writes, and `cke_i` low, never raise `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable; low means power-down or self-refresh |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 3 | Bank address / mode register select |
| addr_i | input | ADDR_W | Address bus |
| bank_idle_i | input | NUM_BANKS | Per-bank precharged-and-settled flags |
| mpr_en_o | output | 1 | MPR mode active |
| rd_src_mpr_o | output | 1 | Current read is served by the MPR |
| mpr_data_o | output | DQ_W | Calibration pattern beat |
| mpr_valid_o | output | 1 | Pattern beat valid |
| err_o | output | 1 | One-cycle illegal-command pulse |

## Verification
The assertions check the following on every cycle:
- mode entry and exit happen only after a matching mode-register-3 write;
- the read select never appears outside MPR mode;
- pattern data is zero when the strobe is low and zero on the first beat;
- writes during MPR mode, busy-bank and reserved-bit writes in normal mode raise the error, and legal normal-mode traffic does not.

The exact latency and eight-beat length of a burst, and the beat-by-beat alternation, are shown only by the bench scenarios. The same holds for the complete sweeps over bank-address codes, reserved address bits, location codes, idle masks and command codes, and for reset cutting a burst short.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_ZQ  = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef struct packed {
    logic nop;
    logic mrs;
    logic rd;
  } cmd_cls_t;
endpackage

// File: rtl/mpr_cmd_decode.sv
module mpr_cmd_decode
  import mpr_pkg::*;
(
  input  logic     cs_ni,
  input  logic     ras_ni,
  input  logic     cas_ni,
  input  logic     we_ni,
  output cmd_cls_t cls_o
);
  cmd_e code;
  assign code = cmd_e'({ras_ni, cas_ni, we_ni});

  always_comb begin
    cls_o = '0;
    if (cs_ni) cls_o.nop = 1'b1;
    else begin
      unique case (code)
        CMD_NOP: cls_o.nop = 1'b1;
        CMD_MRS: cls_o.mrs = 1'b1;
        CMD_RD:  cls_o.rd  = 1'b1;
        default: cls_o     = '0;
      endcase
    end
  end
endmodule

// File: rtl/mpr_mode_ctrl.sv
module mpr_mode_ctrl
  import mpr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cmd_cls_t             cls_i,
  input  logic                 cke_i,
  input  logic [2:0]           ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_BANKS-1:0] bank_idle_i,
  output logic                 mpr_en_o,
  output logic                 err_o,
  output logic                 redirect_o
);
  logic mr3_tgt, rsv_bad, loc_bad, busy, mr3_ok, mr3_err;
  logic en_nxt, err_nxt;

  assign mr3_tgt = (ba_i[1:0] == 2'b11);
  assign rsv_bad = ba_i[2] | (|addr_i[ADDR_W-1:3]);
  assign loc_bad = addr_i[2] & (addr_i[1:0] != 2'b00);
  assign busy    = ~(&bank_idle_i);
  assign mr3_ok  = cls_i.mrs & cke_i & mr3_tgt & ~rsv_bad & ~loc_bad & ~busy;
  assign mr3_err = cls_i.mrs & mr3_tgt & ~mr3_ok;

  always_comb begin
    en_nxt  = mpr_en_o;
    err_nxt = 1'b0;
    if (!mpr_en_o) begin
      if (mr3_err)     err_nxt = 1'b1;
      else if (mr3_ok) en_nxt  = addr_i[2];
    end else begin
      // only NOP/deselect, reads and the disabling MR3 write are legal
      if (!cke_i)                      err_nxt = 1'b1;
      else if (cls_i.rd || cls_i.nop)  err_nxt = 1'b0;
      else if (mr3_ok && !addr_i[2])   en_nxt  = 1'b0;
      else                             err_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpr_en_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      mpr_en_o <= en_nxt;
      err_o    <= err_nxt;
    end
  end

  assign redirect_o = mpr_en_o & cls_i.rd & cke_i;
endmodule

// File: rtl/mpr_burst_gen.sv
module mpr_burst_gen #(
  parameter int DQ_W   = 16,
  parameter int RD_LAT = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            valid_o,
  output logic [DQ_W-1:0] data_o
);
  localparam int BURST_LEN = 8;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  logic [RD_LAT-1:0] dly;
  logic [BEAT_W-1:0] beat;

  generate
    if (RD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly <= '0;
        else         dly <= start_i;
      end
    end else begin : g_latn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly <= '0;
        else         dly <= {dly[RD_LAT-2:0], start_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      beat    <= '0;
    end else if (dly[RD_LAT-1]) begin
      valid_o <= 1'b1;
      beat    <= '0;
    end else if (valid_o) begin
      if (beat == BEAT_W'(BURST_LEN - 1)) valid_o <= 1'b0;
      beat <= beat + 1'b1;
    end
  end

  // alternating 0/1 per beat on every data bit
  assign data_o = valid_o ? {DQ_W{beat[0]}} : '0;
endmodule

// File: rtl/mpr_cmd_unit.sv
module mpr_cmd_unit
  import mpr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 8,
  parameter int DQ_W      = 16,
  parameter int RD_LAT    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [2:0]           ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_BANKS-1:0] bank_idle_i,
  output logic                 mpr_en_o,
  output logic                 rd_src_mpr_o,
  output logic [DQ_W-1:0]      mpr_data_o,
  output logic                 mpr_valid_o,
  output logic                 err_o
);
  cmd_cls_t cls;

  mpr_cmd_decode u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cls_o  (cls)
  );

  mpr_mode_ctrl #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cls_i       (cls),
    .cke_i       (cke_i),
    .ba_i        (ba_i),
    .addr_i      (addr_i),
    .bank_idle_i (bank_idle_i),
    .mpr_en_o    (mpr_en_o),
    .err_o       (err_o),
    .redirect_o  (rd_src_mpr_o)
  );

  mpr_burst_gen #(.DQ_W(DQ_W), .RD_LAT(RD_LAT)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rd_src_mpr_o),
    .valid_o (mpr_valid_o),
    .data_o  (mpr_data_o)
  );
endmodule

// File: rtl/mpr_cmd_chk.sv
module mpr_cmd_chk #(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 8,
  parameter int DQ_W      = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cke_i,
  input logic                 cs_ni,
  input logic                 ras_ni,
  input logic                 cas_ni,
  input logic                 we_ni,
  input logic [2:0]           ba_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [NUM_BANKS-1:0] bank_idle_i,
  input logic                 mpr_en_o,
  input logic                 rd_src_mpr_o,
  input logic [DQ_W-1:0]      mpr_data_o,
  input logic                 mpr_valid_o,
  input logic                 err_o
);
  logic mrs_c, wr_c, mr3_c;
  assign mrs_c = !cs_ni && !ras_ni && !cas_ni && !we_ni;
  assign wr_c  = !cs_ni && !ras_ni && cas_ni && we_ni ? 1'b0 : (!cs_ni && ras_ni && !cas_ni && !we_ni);
  assign mr3_c = mrs_c && (ba_i[1:0] == 2'b11);

  assert_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mpr_en_o) |-> $past(mr3_c && addr_i[2]));

  assert_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mpr_en_o) |-> $past(mr3_c && !addr_i[2]));

  assert_sel_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_src_mpr_o |-> mpr_en_o);

  assert_idle_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mpr_valid_o |-> (mpr_data_o == '0));

  assert_first_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mpr_valid_o) |-> (mpr_data_o == '0));

  assert_wr_in_mpr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mpr_en_o && cke_i && wr_c) |=> (err_o && mpr_en_o));

  assert_busy_bank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mpr_en_o && mr3_c && !(&bank_idle_i)) |=> (err_o && !mpr_en_o));

  assert_rsv_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mpr_en_o && mr3_c && (|addr_i[ADDR_W-1:3])) |=> err_o);

  assert_quiet_normal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mpr_en_o && !mr3_c) |=> !err_o);
endmodule

bind mpr_cmd_unit mpr_cmd_chk #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .DQ_W(DQ_W)) u_chk (.*);

// File: tb/tb_mpr_cmd_unit.sv
module tb_mpr_cmd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int NB     = 8;
  localparam int DQ_W   = 16;
  localparam int RL     = 5;

  logic clk_i = 1'b0;
  logic rst_ni, cke_i, cs_ni, ras_ni, cas_ni, we_ni;
  logic [2:0] ba_i;
  logic [ADDR_W-1:0] addr_i;
  logic [NB-1:0] bank_idle_i;
  logic mpr_en_o, rd_src_mpr_o, mpr_valid_o, err_o;
  logic [DQ_W-1:0] mpr_data_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mpr_cmd_unit #(.ADDR_W(ADDR_W), .NUM_BANKS(NB), .DQ_W(DQ_W), .RD_LAT(RL)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic cs, logic [2:0] c, logic [2:0] ba, logic [ADDR_W-1:0] a);
    cs_ni = cs; {ras_ni, cas_ni, we_ni} = c; ba_i = ba; addr_i = a;
  endtask

  task automatic idle_bus();
    drive(1'b0, 3'b111, 3'b000, '0);
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic issue(logic cs, logic [2:0] c, logic [2:0] ba, logic [ADDR_W-1:0] a);
    drive(cs, c, ba, a);
    step();
    idle_bus();
  endtask

  task automatic mpr_on();
    issue(1'b0, 3'b000, 3'b011, 16'h0004);
  endtask

  task automatic mpr_off();
    issue(1'b0, 3'b000, 3'b011, 16'h0000);
  endtask

  task automatic drain();
    repeat (RL + 10) step();
  endtask

  // checks one burst started by a read just issued
  task automatic check_burst(string req);
    for (int i = 1; i <= RL + 9; i++) begin
      step();
      if (i >= RL && i <= RL + 7) begin
        chk({req, " valid"}, 32'(mpr_valid_o), 32'd1);
        chk({req, " data"}, 32'(mpr_data_o), ((i - RL) % 2 == 1) ? 32'h0000_ffff : 32'h0);
      end else begin
        chk({req, " valid off"}, 32'(mpr_valid_o), 32'd0);
        chk({req, " data off"}, 32'(mpr_data_o), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; cke_i = 1'b1; bank_idle_i = '1;
    drive(1'b1, 3'b111, 3'b000, '0);
    repeat (3) step();
    // R1
    chk("R1 en", 32'(mpr_en_o), 0);
    chk("R1 valid", 32'(mpr_valid_o), 0);
    chk("R1 err", 32'(err_o), 0);
    chk("R1 data", 32'(mpr_data_o), 0);
    rst_ni = 1'b1;
    step();

    // R3/R4/R2: sweep bank-address codes with A2=1
    for (int b = 0; b < 8; b++) begin
      issue(1'b0, 3'b000, 3'(b), 16'h0004);
      chk("R3 ba sweep en", 32'(mpr_en_o), (b == 3) ? 32'd1 : 32'd0);
      chk("R4 ba sweep err", 32'(err_o), (b == 7) ? 32'd1 : 32'd0);
      if (b == 3) begin
        mpr_off();
        chk("R2 off", 32'(mpr_en_o), 0);
        chk("R2 off err", 32'(err_o), 0);
      end
    end

    // R2: A1:A0 ignored on disable
    for (int l = 0; l < 4; l++) begin
      mpr_on();
      chk("R2 on", 32'(mpr_en_o), 1);
      issue(1'b0, 3'b000, 3'b011, 16'(l));
      chk("R2 loc ignored en", 32'(mpr_en_o), 0);
      chk("R2 loc ignored err", 32'(err_o), 0);
    end

    // R4: each reserved address bit
    for (int b = 3; b < ADDR_W; b++) begin
      issue(1'b0, 3'b000, 3'b011, 16'(32'h4 | (32'h1 << b)));
      chk("R4 rsv err", 32'(err_o), 1);
      chk("R4 rsv en", 32'(mpr_en_o), 0);
    end

    // R5: reserved locations
    for (int l = 1; l < 4; l++) begin
      issue(1'b0, 3'b000, 3'b011, 16'(4 + l));
      chk("R5 loc err", 32'(err_o), 1);
      chk("R5 loc en", 32'(mpr_en_o), 0);
    end

    // R6: each bank busy
    for (int k = 0; k < NB; k++) begin
      bank_idle_i = ~(NB'(1) << k);
      mpr_on();
      chk("R6 busy err", 32'(err_o), 1);
      chk("R6 busy en", 32'(mpr_en_o), 0);
    end
    bank_idle_i = '1;

    // R11/R7: normal-mode command sweep, no error, no redirect
    for (int c = 1; c < 8; c++) begin
      drive(1'b0, 3'(c), 3'b000, '0);
      #1 chk("R7 normal sel", 32'(rd_src_mpr_o), 0);
      step(); idle_bus();
      chk("R11 normal err", 32'(err_o), 0);
    end
    cke_i = 1'b0; step(); cke_i = 1'b1;
    chk("R11 cke low", 32'(err_o), 0);
    issue(1'b0, 3'b101, 3'b000, '0);
    for (int i = 0; i < RL + 9; i++) begin
      step();
      chk("R7 no burst", 32'(mpr_valid_o), 0);
    end

    // R9: MPR-mode command sweep
    mpr_on();
    for (int c = 0; c < 8; c++) begin
      drive(1'b0, 3'(c), 3'b000, '0);
      #1 chk("R7 mpr sel", 32'(rd_src_mpr_o), (c == 5) ? 32'd1 : 32'd0);
      step(); idle_bus();
      chk("R9 cmd err", 32'(err_o), (c == 5 || c == 7) ? 32'd0 : 32'd1);
      chk("R9 mode kept", 32'(mpr_en_o), 1);
      drain();
    end
    issue(1'b1, 3'b000, 3'b000, '0);
    chk("R9 deselect", 32'(err_o), 0);
    mpr_on();
    chk("R9 reenable err", 32'(err_o), 1);
    chk("R9 reenable en", 32'(mpr_en_o), 1);
    cke_i = 1'b0; step(); cke_i = 1'b1;
    chk("R9 cke err", 32'(err_o), 1);
    chk("R9 cke en", 32'(mpr_en_o), 1);

    // R8: RD and RDA bursts
    issue(1'b0, 3'b101, 3'b000, '0);
    check_burst("R8 rd");
    issue(1'b0, 3'b101, 3'b000, 16'h0400);
    check_burst("R8 rda");

    // R10: reset mid-burst
    issue(1'b0, 3'b101, 3'b000, '0);
    repeat (RL + 2) step();
    chk("R10 burst live", 32'(mpr_valid_o), 1);
    rst_ni = 1'b0;
    #1;
    chk("R10 en", 32'(mpr_en_o), 0);
    chk("R10 valid", 32'(mpr_valid_o), 0);
    chk("R10 data", 32'(mpr_data_o), 0);
    step(); rst_ni = 1'b1;
    repeat (10) begin
      step();
      chk("R10 stays off", 32'(mpr_valid_o), 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule